// File: doc/BRIEF.md
# External Interrupt Trigger Capture

This block sits in front of the request latches of the external interrupt groups. A set of asynchronous interrupt lines enters it. Each line passes through a synchronizer, and the block turns the activity on that line into a single-cycle request-set strobe for the group that owns the line. How a line is interpreted depends on its 2-bit trigger mode. In an edge mode any change of the synchronized input sets the request, whatever its direction. In a level mode a synchronized value of one sets the request and a zero does nothing.

The trigger modes sit in byte-wide mode registers. Each byte packs four 2-bit fields, and a small byte read/write port reaches them. The default build has eight lines in two mode bytes. Byte 0 serves lines 0 to 3 and byte 1 serves lines 4 to 7. The group request storage and the priority logic sit downstream and are not part of this block. The block also brings out the synchronized line values so that the owner can read back the sampled state of each line.

Top module: `ext_irq_capture`

## Requirements
- R1: After reset every trigger field holds code 3, so mode bytes 0 and 1 both read 0xFF, no request strobe is asserted and the sampled line outputs are zero.
- R2: Trigger codes are 0 = active low, 1 = active high, 2 = rising edge and 3 = falling edge. Line k is configured by mode byte k/4, bits 2(k%4)+1 : 2(k%4). A byte written at offset 0 or 1 reads back unchanged at the same offset.
- R3: Mode offsets other than 0 and 1 read as 0x00, and writes to them leave both mode bytes unchanged.
- R4: Each line passes through two synchronizer flops. A change on an input shows on `line_sampled`, and on any request it causes, in the cycle after the second rising clock edge, and not after the first edge.
- R5: In either edge mode (code 2 or 3), every change of the synchronized input gives a request strobe lasting exactly one cycle, for a rise and for a fall alike. A stable input gives none.
- R6: In either level mode (code 0 or 1), the strobe is high in every cycle in which the synchronized input is one and low whenever it is zero. The polarity code has no effect.
- R7: Rewriting a trigger mode while the inputs are stable produces no request strobe by itself.
- R8: Each line is judged only by its own input and its own field. Lines in different modes in the same cycle give independent strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | NUM_LINES | Asynchronous external interrupt inputs |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_addr | input | ADDR_W | Mode register byte offset |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read data (combinational from `cfg_addr`) |
| line_sampled | output | NUM_LINES | Synchronized value of each line |
| req_set | output | NUM_LINES | One request-set strobe per line |

## Verification
The capture logic is driven with rising, falling and mixed transitions on all lines. Each transition pattern is applied in all four trigger codes. Comparing the rising-edge and falling-edge codes shows whether the edge direction is wrongly honoured. Comparing the active-low and active-high codes on the same data shows whether a polarity inversion has crept in. A mixed-mode pattern, with edge lines and level lines in both bytes, exposes swapped field positions and swapped bytes. Directed sequences measure the two-edge latency edge by edge. Further sequences rewrite the mode while the inputs are stable, and probe the offsets that hold no register.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  localparam int TRIG_W = 2;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_t;

  // Both edge codes share the upper bit.
  function automatic logic trig_is_edge(input logic [TRIG_W-1:0] mode);
    return (mode == TRIG_RISE) || (mode == TRIG_FALL);
  endfunction

  // Request decision for one line from current and previous sample.
  function automatic logic trig_fire(input logic [TRIG_W-1:0] mode,
                                     input logic cur,
                                     input logic prev);
    if (trig_is_edge(mode))
      return cur ^ prev;
    else
      return cur;
  endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ecap_mode_regs.sv
module ecap_mode_regs
  import ecap_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [NUM_BYTES*8-1:0] modes_flat
);

  localparam int FIELDS_PER_BYTE = 8 / TRIG_W;
  localparam logic [7:0] RESET_BYTE = {FIELDS_PER_BYTE{TRIG_FALL}};

  logic [7:0] mode_q [NUM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BYTES; b++) mode_q[b] <= RESET_BYTE;
    end else if (we) begin
      for (int b = 0; b < NUM_BYTES; b++)
        if (int'(addr) == b) mode_q[b] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (int'(addr) == b) rdata = mode_q[b];
  end

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BYTES; gb++) begin : g_flat
      assign modes_flat[gb*8 +: 8] = mode_q[gb];
    end
  endgenerate

endmodule

// File: rtl/ecap_line_detect.sv
module ecap_line_detect
  import ecap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur,
  input  logic [TRIG_W-1:0] mode,
  output logic              prev_q,
  output logic              req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign req = trig_fire(mode, cur, prev_q);

endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
  import ecap_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [NUM_LINES-1:0] line_sampled,
  output logic [NUM_LINES-1:0] req_set
);

  localparam int FIELDS_PER_BYTE = 8 / TRIG_W;
  localparam int NUM_BYTES = (NUM_LINES + FIELDS_PER_BYTE - 1) / FIELDS_PER_BYTE;

  // Named internal events, visible to the bound checker.
  logic [NUM_LINES-1:0]   sync_lines;
  logic [NUM_LINES-1:0]   cache_lines;
  logic [NUM_LINES-1:0]   edge_mode;
  logic [NUM_BYTES*8-1:0] modes_flat;

  ecap_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_lines),
    .dout (sync_lines)
  );

  ecap_mode_regs #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .modes_flat(modes_flat)
  );

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
      logic [TRIG_W-1:0] line_mode;
      assign line_mode     = modes_flat[gl*TRIG_W +: TRIG_W];
      assign edge_mode[gl] = trig_is_edge(line_mode);
      ecap_line_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (sync_lines[gl]),
        .mode  (line_mode),
        .prev_q(cache_lines[gl]),
        .req   (req_set[gl])
      );
    end
  endgenerate

  assign line_sampled = sync_lines;

endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [NUM_LINES-1:0] sync_lines,
  input logic [NUM_LINES-1:0] edge_mode,
  input logic [NUM_LINES-1:0] req_set,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [7:0]           cfg_rdata
);

  // R3: offsets without a register read as zero
  assert_hole_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_addr) >= 2) |-> (cfg_rdata == 8'h00));

  // R4: synchronized value lags the pin by two edges
  assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lines == $past(irq_lines, 2));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_chk
      // R5: edge lines strobe exactly when the sample changed
      assert_edge_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode[gi] |-> (req_set[gi] == (sync_lines[gi] != $past(sync_lines[gi]))));
      // R6: level lines follow the sample regardless of polarity code
      assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode[gi] |-> (req_set[gi] == sync_lines[gi]));
    end
  endgenerate

endmodule

bind ext_irq_capture ecap_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .sync_lines(sync_lines),
  .edge_mode (edge_mode),
  .req_set   (req_set),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata)
);

// File: tb/sim_ext_irq_capture.sv
`timescale 1ns/1ps
module sim_ext_irq_capture;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] line_sampled;
  logic [7:0] req_set;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  ext_irq_capture u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .line_sampled(line_sampled),
    .req_set     (req_set)
  );

  // {mode0, mode1, old, new, strobe after two edges, strobe one cycle later}
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F, 8'h00},  // R5 falling-code, rise
    {8'hFF, 8'hFF, 8'h0F, 8'h03, 8'h0C, 8'h00},  // R5 falling-code, fall
    {8'hAA, 8'hAA, 8'h00, 8'hF0, 8'hF0, 8'h00},  // R5 rising-code, rise
    {8'hAA, 8'hAA, 8'hF0, 8'h00, 8'hF0, 8'h00},  // R5 rising-code, fall
    {8'h55, 8'h55, 8'h00, 8'h81, 8'h81, 8'h81},  // R6 high-code
    {8'h00, 8'h00, 8'h00, 8'h3C, 8'h3C, 8'h3C},  // R6 low-code, one asserts
    {8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h00},  // R6 zero gives nothing
    {8'h0F, 8'hF0, 8'hFF, 8'h00, 8'hC3, 8'h00},  // R8 mixed, falling data
    {8'h0F, 8'hF0, 8'h00, 8'hFF, 8'hFF, 8'h3C}   // R8 mixed, rising data
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic settle(input logic [7:0] v);
    @(negedge clk);
    irq_lines = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req in reset", req_set, 8'h00);
    rst_n = 1'b1;
    rd(2'd0, r); check("R1 byte0 reset", r, 8'hFF);
    rd(2'd1, r); check("R1 byte1 reset", r, 8'hFF);
    check("R1 sampled after reset", line_sampled, 8'h00);
    check("R1 req after reset", req_set, 8'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] m0, m1, vo, vn, e1, e2;
      {m0, m1, vo, vn, e1, e2} = VEC[i];
      wr(2'd0, m0);
      wr(2'd1, m1);
      settle(vo);
      irq_lines = vn;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check($sformatf("R5/R6/R8 vec%0d first", i), req_set, e1);
      check($sformatf("R4 vec%0d sampled", i), line_sampled, vn);
      @(negedge clk);
      check($sformatf("R5/R6/R8 vec%0d second", i), req_set, e2);
    end

    // R2 readback and field position
    wr(2'd0, 8'h1B); rd(2'd0, r); check("R2 byte0 readback", r, 8'h1B);
    wr(2'd1, 8'hE4); rd(2'd1, r); check("R2 byte1 readback", r, 8'hE4);
    // byte1 = E4: line4 low, line5 high, line6 rise, line7 fall; byte0 all fall
    wr(2'd0, 8'hFF);
    settle(8'h00);
    irq_lines = 8'hF0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 field position first", req_set, 8'hF0);
    @(negedge clk);
    check("R2 field position second", req_set, 8'h30);

    // R3 holes
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h12);
    rd(2'd2, r); check("R3 offset2 reads zero", r, 8'h00);
    rd(2'd3, r); check("R3 offset3 reads zero", r, 8'h00);
    rd(2'd0, r); check("R3 byte0 untouched", r, 8'hFF);
    rd(2'd1, r); check("R3 byte1 untouched", r, 8'hE4);

    // R4 latency edge by edge
    wr(2'd1, 8'hFF);
    settle(8'h00);
    irq_lines = 8'h01;
    @(posedge clk); @(negedge clk);
    check("R4 after one edge req", req_set, 8'h00);
    check("R4 after one edge sampled", line_sampled, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R4 after two edges req", req_set, 8'h01);
    check("R4 after two edges sampled", line_sampled, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R4 strobe one cycle", req_set, 8'h00);

    // R7 mode rewrites with stable inputs
    settle(8'h55);
    wr(2'd0, 8'hAA); check("R7 edge->edge byte0", req_set, 8'h00);
    wr(2'd1, 8'hAA); check("R7 edge->edge byte1", req_set, 8'h00);
    @(negedge clk);  check("R7 hold", req_set, 8'h00);
    settle(8'h00);
    wr(2'd0, 8'h00); check("R7 edge->level zero input", req_set, 8'h00);
    wr(2'd0, 8'hFF); check("R7 level->edge", req_set, 8'h00);
    @(negedge clk);  check("R7 hold2", req_set, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule